// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator datapath. Each cycle in which the start strobe is high, it takes the current accumulator value, a second operand and an operation code. One clock later it presents a registered result, a one-cycle write-enable and the updated carry, zero and sign flags. The surrounding datapath decides where the result goes: the accumulator write-enable means the result replaces the accumulator, and the operand write-enable means it goes back to the operand register.

Six operations are supported: add, subtract, compare, exclusive-OR, accumulator complement and operand decrement. Compare produces the same flags as subtract but writes nothing. Complement changes the accumulator and leaves every flag as it was. Decrement updates zero and sign and keeps the previous carry. Branch logic outside the block reads the flags.

Top module: `acc_alu`

## Requirements
- R1: Add (op_i = 3'd0) gives result_o = (acc_i + opnd_i) mod 256 with carry_o = 1 exactly when the unsigned sum exceeds FFh, and raises acc_we_o.
- R2: Subtract (op_i = 3'd1) gives result_o = (acc_i - opnd_i) mod 256 with carry_o = 1 exactly when acc_i < opnd_i, and raises acc_we_o (for example 3Ah - 49h = F1h with carry 1 and sign 1).
- R3: Compare (op_i = 3'd2) sets carry, zero and sign exactly as subtract would: carry 1 and zero 0 when acc_i < opnd_i, zero 1 and carry 0 when they are equal, and both 0 when acc_i > opnd_i. It raises no write-enable and leaves result_o unchanged.
- R4: Exclusive-OR (op_i = 3'd3) gives result_o = acc_i ^ opnd_i, clears carry_o and raises acc_we_o.
- R5: Complement (op_i = 3'd4) gives result_o = ~acc_i, raises acc_we_o and leaves carry_o, zero_o and sign_o unchanged.
- R6: Decrement (op_i = 3'd5) gives result_o = (opnd_i - 1) mod 256, raises opnd_we_o and not acc_we_o, and leaves carry_o unchanged.
- R7: After add, subtract, compare, exclusive-OR or decrement, sign_o equals bit 7 of the computed value (the difference, for compare).
- R8: After add, subtract, compare, exclusive-OR or decrement, zero_o is 1 exactly when the computed value is 00h.
- R9: Results, flags and write-enables change on the first rising clock edge after a start strobe. A write-enable is high for that one cycle only.
- R10: A cycle without start, or with start and a reserved code (op_i = 3'd6 or 3'd7), lowers both write-enables and leaves result_o and all flags unchanged.
- R11: While rst_ni is low, result_o, both write-enables and all flags are 0, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Executes op_i this cycle |
| op_i | input | 3 | Operation code |
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Second operand / register being decremented |
| result_o | output | 8 | Registered result |
| acc_we_o | output | 1 | result_o is to be written to the accumulator |
| opnd_we_o | output | 1 | result_o is to be written to the operand register |
| carry_o | output | 1 | Carry / borrow flag |
| zero_o | output | 1 | Zero flag |
| sign_o | output | 1 | Sign flag |

## Verification
Compare is driven with the accumulator below, equal to and above the operand. These three cases separate the borrow and zero behaviour. Subtract uses 3Ah and 49h, where a result with sign 1 and carry 1 exposes a swapped operand order or an inverted borrow. A two-step exclusive-OR sequence on 87h shows the sign flag both clearing and setting. A repeated add-and-decrement loop forms 0Ah times 0Bh. It exercises carry being kept across decrements and zero rising exactly when the counter reaches 00h. Complement, reserved codes and idle cycles are placed right after flag-setting operations, so that any disturbance of the flags shows up. Decrement of 00h and an add that overflows test the wrap-around edges.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_CMP = 3'd2,
    OP_XOR = 3'd3,
    OP_CPL = 3'd4,
    OP_DEC = 3'd5,
    OP_RS6 = 3'd6,
    OP_RS7 = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic acc_we;
    logic opnd_we;
    logic load_res;
    logic upd_c;
    logic upd_zs;
    logic sel_logic;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic      start_i,
  input  logic [2:0] op_i,
  output alu_ctrl_t ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    if (start_i) begin
      unique case (alu_op_e'(op_i))
        OP_ADD, OP_SUB: begin
          ctrl_o.acc_we   = 1'b1;
          ctrl_o.load_res = 1'b1;
          ctrl_o.upd_c    = 1'b1;
          ctrl_o.upd_zs   = 1'b1;
        end
        OP_CMP: begin
          ctrl_o.upd_c  = 1'b1;
          ctrl_o.upd_zs = 1'b1;
        end
        OP_XOR: begin
          ctrl_o.acc_we    = 1'b1;
          ctrl_o.load_res  = 1'b1;
          ctrl_o.upd_c     = 1'b1;
          ctrl_o.upd_zs    = 1'b1;
          ctrl_o.sel_logic = 1'b1;
        end
        OP_CPL: begin
          ctrl_o.acc_we    = 1'b1;
          ctrl_o.load_res  = 1'b1;
          ctrl_o.sel_logic = 1'b1;
        end
        OP_DEC: begin
          ctrl_o.opnd_we  = 1'b1;
          ctrl_o.load_res = 1'b1;
          ctrl_o.upd_zs   = 1'b1;
        end
        default: ctrl_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         carry_o
);

  logic [W:0] sum_w, diff_w, dec_w;

  assign sum_w  = {1'b0, a_i} + {1'b0, b_i};
  assign diff_w = {1'b0, a_i} - {1'b0, b_i};  // bit W is the borrow
  assign dec_w  = {1'b0, b_i} - (W+1)'(1);

  always_comb begin
    unique case (alu_op_e'(op_i))
      OP_ADD:         {carry_o, res_o} = sum_w;
      OP_SUB, OP_CMP: {carry_o, res_o} = diff_w;
      OP_DEC:         {carry_o, res_o} = dec_w;
      default:        {carry_o, res_o} = '0;
    endcase
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);

  always_comb begin
    unique case (alu_op_e'(op_i))
      OP_XOR:  res_o = a_i ^ b_i;
      OP_CPL:  res_o = ~a_i;
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  output logic [W-1:0] result_o,
  output logic         acc_we_o,
  output logic         opnd_we_o,
  output logic         carry_o,
  output logic         zero_o,
  output logic         sign_o
);

  localparam int unsigned MSB = W - 1;

  alu_ctrl_t    ctrl;
  logic [W-1:0] arith_res, logic_res, calc_res;
  logic         arith_c, calc_c;

  alu_ctrl u_ctrl (
    .start_i (start_i),
    .op_i    (op_i),
    .ctrl_o  (ctrl)
  );

  alu_arith #(.W(W)) u_arith (
    .op_i    (op_i),
    .a_i     (acc_i),
    .b_i     (opnd_i),
    .res_o   (arith_res),
    .carry_o (arith_c)
  );

  alu_logic #(.W(W)) u_logic (
    .op_i  (op_i),
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .res_o (logic_res)
  );

  assign calc_res = ctrl.sel_logic ? logic_res : arith_res;
  assign calc_c   = ctrl.sel_logic ? 1'b0 : arith_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      acc_we_o  <= 1'b0;
      opnd_we_o <= 1'b0;
      carry_o   <= 1'b0;
      zero_o    <= 1'b0;
      sign_o    <= 1'b0;
    end else begin
      acc_we_o  <= ctrl.acc_we;
      opnd_we_o <= ctrl.opnd_we;
      if (ctrl.load_res) result_o <= calc_res;
      if (ctrl.upd_c)    carry_o  <= calc_c;
      if (ctrl.upd_zs) begin
        zero_o <= (calc_res == '0);
        sign_o <= calc_res[MSB];
      end
    end
  end

  // compare never writes
  assert_cmp_nowrite_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == OP_CMP) |=> (!acc_we_o && !opnd_we_o && $stable(result_o)));

  assert_xor_clr_c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == OP_XOR) |=> !carry_o);

  assert_cpl_flags_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == OP_CPL) |=> ($stable(carry_o) && $stable(zero_o) && $stable(sign_o)));

  assert_dec_keep_c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == OP_DEC) |=> ($stable(carry_o) && opnd_we_o && !acc_we_o));

  assert_sign_msb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (op_i == OP_ADD || op_i == OP_SUB || op_i == OP_XOR || op_i == OP_DEC))
    |=> (sign_o == result_o[MSB]));

  assert_zero_res_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (op_i == OP_ADD || op_i == OP_SUB || op_i == OP_XOR || op_i == OP_DEC))
    |=> (zero_o == (result_o == '0)));

  assert_we_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acc_we_o, opnd_we_o}));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i || op_i == OP_RS6 || op_i == OP_RS7)
    |=> (!acc_we_o && !opnd_we_o && $stable(result_o) &&
         $stable(carry_o) && $stable(zero_o) && $stable(sign_o)));

endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] op_i = 3'd0;
  logic [7:0] acc_i = 8'h00;
  logic [7:0] opnd_i = 8'h00;
  logic [7:0] result_o;
  logic       acc_we_o, opnd_we_o, carry_o, zero_o, sign_o;

  int checks = 0;
  int errors = 0;

  int e_res = 0, e_awe = 0, e_owe = 0, e_c = 0, e_z = 0, e_s = 0;

  always #10 clk_i = ~clk_i;

  acc_alu u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .acc_i(acc_i), .opnd_i(opnd_i), .result_o(result_o), .acc_we_o(acc_we_o),
    .opnd_we_o(opnd_we_o), .carry_o(carry_o), .zero_o(zero_o), .sign_o(sign_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "result", int'(result_o), e_res);
    chk(req, "acc_we", int'(acc_we_o), e_awe);
    chk(req, "opnd_we", int'(opnd_we_o), e_owe);
    chk(req, "carry", int'(carry_o), e_c);
    chk(req, "zero", int'(zero_o), e_z);
    chk(req, "sign", int'(sign_o), e_s);
  endtask

  // called at a negedge; drives, predicts, checks at next negedge
  task automatic step(input string req, input bit st, input int op, input int a, input int b);
    int v;
    start_i = st; op_i = 3'(op); acc_i = 8'(a); opnd_i = 8'(b);
    e_awe = 0; e_owe = 0;
    if (st) begin
      case (op)
        0: begin v = a + b; e_res = v % 256; e_c = (v > 255); e_awe = 1;
                 e_z = (e_res == 0); e_s = e_res / 128; end
        1: begin v = (a - b + 256) % 256; e_res = v; e_c = (a < b); e_awe = 1;
                 e_z = (v == 0); e_s = v / 128; end
        2: begin v = (a - b + 256) % 256; e_c = (a < b);
                 e_z = (v == 0); e_s = v / 128; end
        3: begin e_res = a ^ b; e_c = 0; e_awe = 1;
                 e_z = (e_res == 0); e_s = e_res / 128; end
        4: begin e_res = 255 - a; e_awe = 1; end
        5: begin e_res = (b + 255) % 256; e_owe = 1;
                 e_z = (e_res == 0); e_s = e_res / 128; end
        default: ;
      endcase
    end
    @(posedge clk_i);
    @(negedge clk_i);
    chk_all(req);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int acc, cnt;
    @(negedge clk_i);
    chk_all("R11");  // reset state, all zero
    @(negedge clk_i);
    rst_ni = 1'b1;

    step("R9", 0, 0, 0, 0);
    step("R1", 1, 0, 8'h12, 8'h34);
    step("R1", 1, 0, 8'hF0, 8'h20);   // overflow
    step("R8", 1, 0, 8'h80, 8'h80);   // zero with carry
    step("R9", 0, 0, 8'h55, 8'h55);   // write-enable drops
    step("R2", 1, 1, 8'h3A, 8'h49);
    chk("R2", "sub F1", int'(result_o), 8'hF1);
    step("R5", 1, 4, 8'h0F, 8'h00);   // flags untouched
    step("R3", 1, 2, 8'h10, 8'h20);   // below
    step("R3", 1, 2, 8'h20, 8'h20);   // equal
    step("R3", 1, 2, 8'h90, 8'h20);   // above
    step("R4", 1, 3, 8'h87, 8'h87);
    step("R7", 1, 3, 8'h00, 8'h87);
    step("R10", 1, 6, 8'h01, 8'h02);
    step("R10", 1, 7, 8'hFF, 8'hFF);
    step("R1", 1, 0, 8'hFF, 8'h01);   // sets carry before decrement
    step("R6", 1, 5, 8'h00, 8'h01);   // to zero, carry kept
    step("R6", 1, 5, 8'h00, 8'h00);   // wraps to FF
    step("R5", 1, 4, 8'hA5, 8'h00);

    // 0Ah times 0Bh by repeated add and decrement
    acc = 0; cnt = 11;
    step("R1", 1, 1, 8'h00, 8'h00);   // clear carry
    do begin
      step("R1", 1, 0, acc, 8'h0A);
      acc = e_res;
      step("R6", 1, 5, 8'h00, cnt);
      cnt = e_res;
    end while (cnt != 0);
    chk("R1", "product", acc, 8'h6E);
    chk("R6", "carry after loop", int'(carry_o), 0);

    // asynchronous reset mid-run
    step("R2", 1, 1, 8'h01, 8'h02);
    #3 rst_ni = 1'b0;
    #2;
    e_res = 0; e_awe = 0; e_owe = 0; e_c = 0; e_z = 0; e_s = 0;
    chk_all("R11");
    @(negedge clk_i);
    rst_ni = 1'b1;
    step("R9", 0, 0, 0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule